// File: doc/BRIEF.md
# TDM Frame Timer and Timeslot Mapper

This block keeps time for a 2048 kbit/s serial bus carrying 32 timeslots per frame. It is clocked at twice the bit rate, so every bit cell lasts two clocks, every timeslot lasts sixteen clocks and a frame lasts 512 clocks. An active-low frame marker resynchronises the counters. If the marker is absent, the counters keep running and wrap on their own. Each cycle the block reports the current timeslot, the clock phase inside that slot and the bit being sent, most significant bit first.

It also converts the timeslot into an address in an external byte buffer. In full mode every slot maps straight to the buffer byte with the same number. In reduced mode one slot in every four, starting at slot 0, is left unused and must carry the filler byte 0xFF. The other 24 slots take buffer bytes 0 to 23 in rising order.

Around each used slot the block produces two framing strobes, one for each half of the slot. It also marks the last clock of each slot as the window in which the serial side reads or writes the buffer. A parallel port that hits the same byte during that window is told to wait.

Top module: `tdm_frame_mapper`

## Requirements
- R1: While reset is low, and at the first sample after it, the position is slot 0, phase 0, with bit index 7.
- R2: Without a frame marker the phase advances by one per clock. The slot number advances each time the phase passes from 15 to 0, and slot 31 phase 15 is followed by slot 0 phase 0, so the position repeats every 512 clocks.
- R3: A high-to-low change of `frame_n`, seen at a rising clock edge, puts the counters at slot 0, phase 0 from that edge on, wherever they stood before.
- R4: `bit_idx` is 7 during phases 0 and 1 and falls by one every two clocks, reaching 0 in phases 14 and 15, so the most significant bit goes first.
- R5: With `sel32` high, every slot is used and `buf_addr` equals the slot number.
- R6: With `sel32` low, slots whose number is a multiple of 4 are unused: `slot_valid` is 0, `fill_ff` is 1 and `buf_addr` is 0. Each remaining slot n takes `buf_addr` = n − floor(n/4) − 1, which runs 0 to 23.
- R7: `soc_n` is low during phases 0 to 7 of a used slot and high at all other times.
- R8: `dsel_n` is low during phases 8 to 15 of a used slot and high at all other times. It is never low at the same time as `soc_n`.
- R9: `cwin` is high in phase 15 of every slot and low in every other phase.
- R10: `busy` is high only when `pa_req` is high, `cwin` is high, the slot is used and `pa_addr` equals `buf_addr`. An access that does not meet all four conditions in that cycle, including one that ended before it, does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame marker; its falling edge restarts the frame |
| sel32 | input | 1 | 1 = 32 used slots, 0 = 24 used slots |
| pa_req | input | 1 | The parallel port is accessing the buffer this cycle |
| pa_addr | input | 5 | Buffer byte addressed by the parallel port |
| slot_num | output | 5 | Current timeslot |
| slot_phase | output | 4 | Clock phase inside the timeslot |
| bit_idx | output | 3 | Bit position now on the line, 7 first |
| buf_addr | output | 5 | Buffer byte for the current timeslot |
| slot_valid | output | 1 | Current timeslot carries buffer data |
| fill_ff | output | 1 | Current timeslot is unused and sends 0xFF |
| soc_n | output | 1 | Active-low strobe for the first half of a used slot |
| dsel_n | output | 1 | Active-low strobe for the second half of a used slot |
| cwin | output | 1 | Serial-side buffer access window (last clock of the slot) |
| busy | output | 1 | The parallel access collides with the serial access; hold off |

## Verification
All outputs come from one 9-bit position register, so a wrong count shows up at the ports at once. A skipped or doubled clock, or a resync that never takes effect, moves `slot_phase` and the strobe edges in the next sample. An error in the slot field shifts `buf_addr` by one or more bytes from then on. A wrong reduced-mode formula gives a wrong address or a missing 0xFF slot within the first four slots after a frame marker. A wrong collision term shows as a `busy` pulse outside phase 15, or as a missing pulse on a matching address in that same cycle.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
   localparam int DEF_SLOTS        = 32;
   localparam int DEF_BITS         = 8;
   localparam int DEF_CLKS_PER_BIT = 2;
   localparam int DEF_SKIP         = 4;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter #(
   parameter int SLOTS = tdm_pkg::DEF_SLOTS,
   parameter int CPS   = tdm_pkg::DEF_BITS * tdm_pkg::DEF_CLKS_PER_BIT,
   localparam int AW   = $clog2(SLOTS),
   localparam int PW   = $clog2(CPS),
   localparam int FW   = AW + PW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_n,
   output logic [AW-1:0] slot,
   output logic [PW-1:0] phase
);
   if (!tdm_pkg::is_pow2(SLOTS) || !tdm_pkg::is_pow2(CPS) || CPS < 2)
      $error("slot count and clocks per slot must be powers of two");

   logic [FW-1:0] cnt;
   logic          fp_q;
   logic          fp_fall;

   assign fp_fall = fp_q & ~frame_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         fp_q <= 1'b1;
      end else begin
         fp_q <= frame_n;
         if (fp_fall) cnt <= '0;
         else         cnt <= cnt + 1'b1;
      end
   end

   assign slot  = cnt[FW-1:PW];
   assign phase = cnt[PW-1:0];

   p_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fp_q && !frame_n) |=> (cnt == '0));

   p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(fp_q && !frame_n) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/tdm_slot_mapper.sv
module tdm_slot_mapper #(
   parameter int SLOTS = tdm_pkg::DEF_SLOTS,
   parameter int SKIP  = tdm_pkg::DEF_SKIP,
   localparam int AW   = $clog2(SLOTS),
   localparam int USED = SLOTS - SLOTS / SKIP
) (
   input  logic          full_mode,
   input  logic [AW-1:0] slot,
   output logic          valid,
   output logic [AW-1:0] addr
);
   if (SKIP < 2 || (SLOTS % SKIP) != 0)
      $error("skip period must be at least 2 and divide the slot count");

   logic          red_valid;
   logic [AW-1:0] red_addr;

   if (tdm_pkg::is_pow2(SKIP)) begin : g_pow2
      localparam int SKW = $clog2(SKIP);
      assign red_valid = (slot[SKW-1:0] != '0);
      assign red_addr  = slot - (slot >> SKW) - AW'(1);
   end else begin : g_generic
      assign red_valid = ((int'(slot) % SKIP) != 0);
      assign red_addr  = AW'(int'(slot) - int'(slot) / SKIP - 1);
   end

   always_comb begin
      if (full_mode) begin
         valid = 1'b1;
         addr  = slot;
      end else begin
         valid = red_valid;
         addr  = red_valid ? red_addr : '0;
      end
   end

   always_comb begin
      if (valid && !full_mode)
         p_addr_range_r6: assert (int'(addr) < USED);
   end
endmodule

// File: rtl/tdm_strobe_gen.sv
module tdm_strobe_gen #(
   parameter int CPS = tdm_pkg::DEF_BITS * tdm_pkg::DEF_CLKS_PER_BIT,
   parameter int AW  = $clog2(tdm_pkg::DEF_SLOTS),
   localparam int PW = $clog2(CPS)
) (
   input  logic [PW-1:0] phase,
   input  logic          valid,
   input  logic [AW-1:0] addr,
   input  logic          pa_req,
   input  logic [AW-1:0] pa_addr,
   output logic          soc_n,
   output logic          dsel_n,
   output logic          cwin,
   output logic          busy
);
   logic second_half;

   assign second_half = phase[PW-1];
   assign soc_n       = ~(valid & ~second_half);
   assign dsel_n      = ~(valid & second_half);
   assign cwin        = (phase == PW'(CPS - 1));
   assign busy        = pa_req & cwin & valid & (pa_addr == addr);

   always_comb begin
      p_strobe_excl_r8: assert (soc_n || dsel_n);
   end
endmodule

// File: rtl/tdm_frame_mapper.sv
module tdm_frame_mapper #(
   parameter int SLOTS        = tdm_pkg::DEF_SLOTS,
   parameter int BITS         = tdm_pkg::DEF_BITS,
   parameter int CLKS_PER_BIT = tdm_pkg::DEF_CLKS_PER_BIT,
   parameter int SKIP         = tdm_pkg::DEF_SKIP,
   localparam int CPS = BITS * CLKS_PER_BIT,
   localparam int AW  = $clog2(SLOTS),
   localparam int PW  = $clog2(CPS),
   localparam int BIW = $clog2(BITS),
   localparam int CBW = $clog2(CLKS_PER_BIT)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           frame_n,
   input  logic           sel32,
   input  logic           pa_req,
   input  logic [AW-1:0]  pa_addr,
   output logic [AW-1:0]  slot_num,
   output logic [PW-1:0]  slot_phase,
   output logic [BIW-1:0] bit_idx,
   output logic [AW-1:0]  buf_addr,
   output logic           slot_valid,
   output logic           fill_ff,
   output logic           soc_n,
   output logic           dsel_n,
   output logic           cwin,
   output logic           busy
);
   if (!tdm_pkg::is_pow2(BITS) || !tdm_pkg::is_pow2(CLKS_PER_BIT))
      $error("bits per slot and clocks per bit must be powers of two");

   tdm_frame_counter #(.SLOTS(SLOTS), .CPS(CPS)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_n (frame_n),
      .slot    (slot_num),
      .phase   (slot_phase)
   );

   tdm_slot_mapper #(.SLOTS(SLOTS), .SKIP(SKIP)) u_map (
      .full_mode (sel32),
      .slot      (slot_num),
      .valid     (slot_valid),
      .addr      (buf_addr)
   );

   tdm_strobe_gen #(.CPS(CPS), .AW(AW)) u_strb (
      .phase   (slot_phase),
      .valid   (slot_valid),
      .addr    (buf_addr),
      .pa_req  (pa_req),
      .pa_addr (pa_addr),
      .soc_n   (soc_n),
      .dsel_n  (dsel_n),
      .cwin    (cwin),
      .busy    (busy)
   );

   assign fill_ff = ~slot_valid;
   assign bit_idx = BIW'(BITS - 1) - BIW'(slot_phase >> CBW);

   p_busy_in_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cwin && slot_valid && pa_req));

   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_num == AW'(SLOTS - 1) && slot_phase == PW'(CPS - 1))
         |=> (slot_num == '0 && slot_phase == '0));

   p_soc_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid && slot_phase == '0) |-> !soc_n);

   p_window_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cwin |=> (slot_phase == '0));
endmodule

// File: tb/tdm_frame_mapper_tb.sv
module tdm_frame_mapper_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_n = 1'b1;
   logic       sel32 = 1'b1;
   logic       pa_req = 1'b0;
   logic [4:0] pa_addr = '0;
   logic [4:0] slot_num, buf_addr;
   logic [3:0] slot_phase;
   logic [2:0] bit_idx;
   logic       slot_valid, fill_ff, soc_n, dsel_n, cwin, busy;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tdm_frame_mapper u_dut (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sel32(sel32),
      .pa_req(pa_req), .pa_addr(pa_addr), .slot_num(slot_num),
      .slot_phase(slot_phase), .bit_idx(bit_idx), .buf_addr(buf_addr),
      .slot_valid(slot_valid), .fill_ff(fill_ff), .soc_n(soc_n),
      .dsel_n(dsel_n), .cwin(cwin), .busy(busy)
   );

   // Fields: sel32, slot, phase, req, pa_addr, exp fill, exp addr, exp busy, spare
   localparam int NV = 10;
   localparam logic [23:0] VEC [NV] = '{
      {1'b1, 5'd0,  4'd0,  1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0},
      {1'b1, 5'd31, 4'd15, 1'b1, 5'd31, 1'b0, 5'd31, 1'b1, 1'b0},
      {1'b0, 5'd0,  4'd3,  1'b0, 5'd0,  1'b1, 5'd0,  1'b0, 1'b0},
      {1'b0, 5'd1,  4'd8,  1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0},
      {1'b0, 5'd31, 4'd15, 1'b1, 5'd23, 1'b0, 5'd23, 1'b1, 1'b0},
      {1'b0, 5'd28, 4'd15, 1'b1, 5'd0,  1'b1, 5'd0,  1'b0, 1'b0},
      {1'b1, 5'd5,  4'd14, 1'b1, 5'd5,  1'b0, 5'd5,  1'b0, 1'b0},
      {1'b1, 5'd5,  4'd15, 1'b1, 5'd6,  1'b0, 5'd5,  1'b0, 1'b0},
      {1'b0, 5'd13, 4'd7,  1'b0, 5'd0,  1'b0, 5'd9,  1'b0, 1'b0},
      {1'b0, 5'd6,  4'd15, 1'b1, 5'd4,  1'b0, 5'd4,  1'b1, 1'b0}
   };

   task automatic check(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic resync(input int n);
      @(negedge clk) frame_n = 1'b0;
      @(negedge clk) frame_n = 1'b1;
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      check("R1", "slot in reset", int'(slot_num), 0);
      check("R1", "phase in reset", int'(slot_phase), 0);
      check("R1", "bit in reset", int'(bit_idx), 7);
      @(negedge clk) rst_n = 1'b1;
      #1;
      check("R1", "phase after release", int'(slot_phase), 0);

      // Table walk: R5 R6 R7 R8 R9 R10
      for (int i = 0; i < NV; i++) begin
         logic [23:0] v;
         int ph;
         bit vld;
         v = VEC[i];
         sel32 = v[23];
         pa_req = 1'b0;
         resync(int'(v[22:18]) * 16 + int'(v[17:14]));
         pa_req  = v[13];
         pa_addr = v[12:8];
         #1;
         ph  = int'(v[17:14]);
         vld = !v[7];
         check(v[23] ? "R5" : "R6", "fill_ff", int'(fill_ff), int'(v[7]));
         check(v[23] ? "R5" : "R6", "buf_addr", int'(buf_addr), int'(v[6:2]));
         check("R7", "soc_n", int'(soc_n), (vld && ph < 8) ? 0 : 1);
         check("R8", "dsel_n", int'(dsel_n), (vld && ph >= 8) ? 0 : 1);
         check("R9", "cwin", int'(cwin), (ph == 15) ? 1 : 0);
         check("R10", "busy", int'(busy), int'(v[1]));
         pa_req = 1'b0;
      end

      // R2: free run across slot boundary and frame wrap
      sel32 = 1'b1;
      resync(16);
      check("R2", "slot after 16 clocks", int'(slot_num), 1);
      check("R2", "phase after 16 clocks", int'(slot_phase), 0);
      resync(512);
      check("R2", "slot after 512 clocks", int'(slot_num), 0);
      check("R2", "phase after 512 clocks", int'(slot_phase), 0);
      repeat (37) @(negedge clk);
      #1;
      check("R2", "slot after wrap+37", int'(slot_num), 2);
      check("R2", "phase after wrap+37", int'(slot_phase), 5);

      // R3: mid-frame resync
      resync(100);
      resync(0);
      check("R3", "slot after resync", int'(slot_num), 0);
      check("R3", "phase after resync", int'(slot_phase), 0);

      // R4: bit order
      resync(1);
      check("R4", "bit at phase 1", int'(bit_idx), 7);
      resync(2);
      check("R4", "bit at phase 2", int'(bit_idx), 6);
      resync(15);
      check("R4", "bit at phase 15", int'(bit_idx), 0);

      // R10: matching address outside window, and request ended before window
      sel32 = 1'b1;
      resync(3 * 16 + 14);
      pa_req = 1'b1; pa_addr = 5'd3;
      #1;
      check("R10", "busy before window", int'(busy), 0);
      @(negedge clk) pa_req = 1'b0;
      #1;
      check("R10", "busy after access ended", int'(busy), 0);
      check("R9", "cwin phase 15", int'(cwin), 1);

      // R6: every reduced-mode slot against the formula
      sel32 = 1'b0;
      resync(0);
      for (int s = 0; s < 32; s++) begin
         int ea;
         ea = (s % 4 == 0) ? 0 : s - s / 4 - 1;
         check("R6", "slot_valid sweep", int'(slot_valid), (s % 4 == 0) ? 0 : 1);
         check("R6", "buf_addr sweep", int'(buf_addr), ea);
         repeat (16) @(negedge clk);
         #1;
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule